// File: doc/BRIEF.md
# Multi-Bank Phase-Skew Clock Generator

This block produces four banks of clock outputs, two identical outputs per bank, from one fast timing clock whose period is the skew unit. A shared phase counter spans four base periods. A range select sets the base period to 8, 16 or 32 skew units. Each bank reads its own pair of three-level select pins. Depending on the bank, the select code moves the bank's phase earlier or later by whole skew units, divides the output by two or four, or inverts it.

A hold input stops the outputs. The stop is applied only when a bank's own wave is already at its resting level, so no short pulse appears at the output. Bank 2 is exempt from the hold so that it can keep serving as the loop feedback clock. When the test select is at mid, the hold stops only those banks whose code is LL. An edge select places the waves on the rising or the falling reference edge.

Top module: `skew_clk_gen`

## Requirements
- R1: Each three-level pin is a 2-bit value (00 = L, 01 = M, 10 = H, 11 is read as M). The phase count j steps by one every clock and wraps after 4·MF counts, where MF is 32, 16 or 8 for range select L, M or H.
- R2: The outputs are registered. After the clock edge that ends phase count j, a running bank drives the wave of p = (j − S + D) mod 4·MF, where S is the bank's skew in units. Divide-by-1 is high for p mod MF < MF/2. Divide-by-2 is high for p mod 2·MF < MF. Divide-by-4 is high for p < 2·MF. Inverted is the complement of divide-by-1.
- R3: The code index is c = 3·upper + lower, where the upper pin is bits [4b+3:4b+2] of the bank select bus and the lower pin is bits [4b+1:4b]. Banks 1 and 2 run divide-by-1 with skew S = c − 4.
- R4: Bank 3 divides by 2 for code LL and by 4 for code HH, both at zero skew. Every other code gives divide-by-1 with S = 2·(c − 4).
- R5: Bank 4 divides by 2 for code LL and is inverted for code HH, both at zero skew. Every other code gives divide-by-1 with S = 2·(c − 4).
- R6: D = MF/2 when the edge select is L, which aligns the outputs to the falling edge. D = 0 when the edge select is M or H.
- R7: While hold is high and test is not M, banks 1, 3 and 4 come to rest LOW. Bank 2 keeps running.
- R8: An inverted bank 4 comes to rest HIGH under hold when the edge select is M or H. It comes to rest LOW when the edge select is L.
- R9: With test at M and hold high, only the banks whose code is LL come to rest. The other banks keep running with their selected settings.
- R10: A bank starts or stops only when its own wave is at its resting level. No high or low run shorter than MF/2 appears on any output.
- R11: A new bank code takes effect from the next phase count that is a multiple of MF. A new range takes effect when j wraps to 0.
- R12: Reset drives every output LOW and sets j to 0, the range to M and every bank code to MM. The two outputs of a bank are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, one skew unit per period |
| rst | input | 1 | Asynchronous reset, active high |
| range_sel_i | input | 2 | Base-period range select (three-level) |
| edge_sel_i | input | 2 | Reference-edge polarity select (three-level) |
| test_sel_i | input | 2 | Test select; M enables per-bank disable (three-level) |
| hold_i | input | 1 | Output stop request, active high |
| bank_sel_i | input | 16 | Four bits per bank: upper pin, then lower pin |
| clk_o | output | 8 | Bank b drives bits [2b+1:2b] |

## Verification
The bench tracks the phase count that each output sample reflects. Every output appears one edge after its count. After reset the bench therefore waits 64 edges, one wrap of the mid range, before the requested range and codes apply, and it checks the first 16 of those edges against the MM reset settings. Code changes are made at a known count, and the expected wave switches at the next multiple of MF. Range changes are followed by waiting out the wrap. Gating is given a settling window of four base periods, during which only run lengths are checked. After that window the resting levels and the running banks are compared every cycle.

// File: rtl/skew_clk_pkg.sv
package skew_clk_pkg;

    localparam int CODE_W = 4;

    typedef enum logic [1:0] {
        TL_LOW  = 2'd0,
        TL_MID  = 2'd1,
        TL_HIGH = 2'd2
    } tri_lvl_e;

    typedef enum logic [1:0] {
        WV_DIV1 = 2'd0,
        WV_DIV2 = 2'd1,
        WV_DIV4 = 2'd2,
        WV_INV  = 2'd3
    } wave_e;

    typedef struct packed {
        wave_e             wave;
        logic signed [3:0] skew;
    } bank_cfg_t;

    localparam logic [CODE_W-1:0] CODE_LL = CODE_W'(0);
    localparam logic [CODE_W-1:0] CODE_MM = CODE_W'(4);
    localparam logic [CODE_W-1:0] CODE_HH = CODE_W'(8);

    // Reserved encoding 11 reads as mid.
    function automatic tri_lvl_e tri_norm(input logic [1:0] raw);
        return (raw == 2'd3) ? TL_MID : tri_lvl_e'(raw);
    endfunction

    // Nine-value code index: upper pin weighs three, lower pin one.
    function automatic logic [CODE_W-1:0] code_index(input logic [3:0] pins);
        return CODE_W'(3 * int'(tri_norm(pins[3:2])) + int'(tri_norm(pins[1:0])));
    endfunction

    function automatic bank_cfg_t bank_decode(input int bank_id, input logic [CODE_W-1:0] code);
        bank_cfg_t cfg;
        int        off;
        off      = int'(code) - 4;
        cfg.wave = WV_DIV1;
        cfg.skew = 4'(off);
        if (bank_id >= 2) begin
            cfg.skew = 4'(2 * off);
            if (code == CODE_LL) begin
                cfg.wave = WV_DIV2;
                cfg.skew = '0;
            end else if (code == CODE_HH) begin
                cfg.wave = (bank_id == 2) ? WV_DIV4 : WV_INV;
                cfg.skew = '0;
            end
        end
        return cfg;
    endfunction

endpackage

// File: rtl/skew_phase_ctr.sv
module skew_phase_ctr
    import skew_clk_pkg::*;
#(
    parameter int MF_MAX = 32,
    parameter int CNT_W  = $clog2(4 * MF_MAX)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       range_sel_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] mf_o,
    output logic             period_end_o
);

    localparam int                 SPAN_W   = CNT_W + 2;
    localparam logic [CNT_W-1:0]   CNT_ONE  = CNT_W'(1);
    localparam logic [SPAN_W-1:0]  SPAN_ONE = SPAN_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        tri_lvl_e         rng;
    } ctr_st_t;

    ctr_st_t           st_d, st_q;
    logic [CNT_W-1:0]  mf;
    logic [SPAN_W-1:0] span;
    logic              wrap;

    always_comb begin
        case (st_q.rng)
            TL_HIGH: mf = CNT_W'(MF_MAX / 4);
            TL_LOW:  mf = CNT_W'(MF_MAX);
            default: mf = CNT_W'(MF_MAX / 2);
        endcase
        span         = {mf, 2'b00};
        wrap         = ({2'b00, st_q.cnt} == (span - SPAN_ONE));
        period_end_o = ((st_q.cnt & (mf - CNT_ONE)) == (mf - CNT_ONE));

        st_d = st_q;
        if (wrap) begin
            st_d.cnt = '0;
            st_d.rng = tri_norm(range_sel_i);
        end else begin
            st_d.cnt = st_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '{cnt: '0, rng: TL_MID};
        else     st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign mf_o  = mf;

    AST_CNT_IN_SPAN: assert property (@(posedge clk) disable iff (rst)
        ({2'b00, st_q.cnt} < span)); // R1
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt != '0) |-> (st_q.cnt == $past(st_q.cnt) + CNT_ONE)); // R1
    AST_RANGE_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (st_q.rng != $past(st_q.rng)) |-> (st_q.cnt == '0)); // R11

endmodule

// File: rtl/skew_bank.sv
module skew_bank
    import skew_clk_pkg::*;
#(
    parameter int BANK_ID = 0,
    parameter int CNT_W   = 7,
    parameter int OUTS    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] mf_i,
    input  logic             period_end_i,
    input  logic [3:0]       sel_i,
    input  logic [1:0]       edge_sel_i,
    input  logic [1:0]       test_sel_i,
    input  logic             hold_i,
    output logic [OUTS-1:0]  q_o
);

    localparam int                CALC_W      = CNT_W + 2;
    localparam logic [CALC_W-1:0] ONE         = CALC_W'(1);
    localparam bit                IS_FEEDBACK = (BANK_ID == 1);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              en;
        logic              out;
    } bank_st_t;

    bank_st_t          st_d, st_q;
    bank_cfg_t         cfg;
    logic              falling, test_mid, nat, stop_lvl, stop_req;
    logic [CALC_W-1:0] mf_x, span, pol_off, skew_x, phase;

    always_comb begin
        cfg      = bank_decode(BANK_ID, st_q.code);
        falling  = (tri_norm(edge_sel_i) == TL_LOW);
        test_mid = (tri_norm(test_sel_i) == TL_MID);
        mf_x     = CALC_W'(mf_i);
        span     = mf_x << 2;
        pol_off  = falling ? (mf_x >> 1) : '0;
        skew_x   = {{(CALC_W-4){cfg.skew[3]}}, cfg.skew};
        phase    = (CALC_W'(cnt_i) + span + pol_off - skew_x) & (span - ONE);

        case (cfg.wave)
            WV_DIV2: nat = ((phase & ((mf_x << 1) - ONE)) < mf_x);
            WV_DIV4: nat = (phase < (mf_x << 1));
            WV_INV:  nat = !((phase & (mf_x - ONE)) < (mf_x >> 1));
            default: nat = ((phase & (mf_x - ONE)) < (mf_x >> 1));
        endcase

        stop_lvl = (cfg.wave == WV_INV) && !falling;
        if (test_mid && hold_i) stop_req = (st_q.code == CODE_LL);
        else                    stop_req = hold_i && !IS_FEEDBACK;

        st_d = st_q;
        if (period_end_i) st_d.code = code_index(sel_i);
        if (nat == stop_lvl) st_d.en = !stop_req;
        st_d.out = st_d.en ? nat : stop_lvl;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '{code: CODE_MM, en: 1'b1, out: 1'b0};
        else     st_q <= st_d;
    end

    assign q_o = {OUTS{st_q.out}};

    AST_CODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        (st_q.code != $past(st_q.code)) |-> $past(period_end_i)); // R11
    AST_GATE_AT_REST: assert property (@(posedge clk) disable iff (rst)
        (st_q.en != $past(st_q.en)) |-> (st_q.out == $past(stop_lvl))); // R10

endmodule

// File: rtl/skew_clk_gen.sv
module skew_clk_gen
    import skew_clk_pkg::*;
#(
    parameter int MF_MAX        = 32,
    parameter int NUM_BANKS     = 4,
    parameter int OUTS_PER_BANK = 2
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [1:0]                         range_sel_i,
    input  logic [1:0]                         edge_sel_i,
    input  logic [1:0]                         test_sel_i,
    input  logic                               hold_i,
    input  logic [4*NUM_BANKS-1:0]             bank_sel_i,
    output logic [NUM_BANKS*OUTS_PER_BANK-1:0] clk_o
);

    localparam int CNT_W = $clog2(4 * MF_MAX);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mf;
    logic             period_end;

    skew_phase_ctr #(
        .MF_MAX (MF_MAX),
        .CNT_W  (CNT_W)
    ) u_ctr (
        .clk          (clk),
        .rst          (rst),
        .range_sel_i  (range_sel_i),
        .cnt_o        (cnt),
        .mf_o         (mf),
        .period_end_o (period_end)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        skew_bank #(
            .BANK_ID (b),
            .CNT_W   (CNT_W),
            .OUTS    (OUTS_PER_BANK)
        ) u_bank (
            .clk          (clk),
            .rst          (rst),
            .cnt_i        (cnt),
            .mf_i         (mf),
            .period_end_i (period_end),
            .sel_i        (bank_sel_i[4*b +: 4]),
            .edge_sel_i   (edge_sel_i),
            .test_sel_i   (test_sel_i),
            .hold_i       (hold_i),
            .q_o          (clk_o[OUTS_PER_BANK*b +: OUTS_PER_BANK])
        );
    end

endmodule

// File: tb/skew_clk_gen_test.sv
module skew_clk_gen_test;

    localparam int CLK_PERIOD = 10;
    localparam int NEVER      = 32'h7fff_ffff;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  range_sel = 2'd1;
    logic [1:0]  edge_sel = 2'd2;
    logic [1:0]  test_sel = 2'd0;
    logic        hold = 1'b0;
    logic [15:0] bank_sel = 16'h5555;
    logic [7:0]  clk_o;

    int nvec = 0;
    int nbad = 0;
    int mf = 16;
    bit pl = 1'b0;
    int t = 0;
    int t_sw = NEVER;
    int code_now[4];
    int code_nxt[4];
    bit stopped[4];
    bit runt_on = 1'b0;
    int run_len[4];
    bit last_lvl[4];

    skew_clk_gen uut (
        .clk         (clk),
        .rst         (rst),
        .range_sel_i (range_sel),
        .edge_sel_i  (edge_sel),
        .test_sel_i  (test_sel),
        .hold_i      (hold),
        .bank_sel_i  (bank_sel),
        .clk_o       (clk_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [3:0] pins_of(input int c);
        return {2'(c / 3), 2'(c % 3)};
    endfunction

    function automatic bit model(input int b, input int c, input int mfv, input bit plv, input int j);
        int sk = 0;
        int md = 0;
        int span = 4 * mfv;
        int p;
        if (b < 2) sk = c - 4;
        else if (c == 0) md = 1;
        else if (c == 8) md = (b == 2) ? 2 : 3;
        else sk = 2 * (c - 4);
        p = ((j - sk + (plv ? mfv / 2 : 0)) % span + span) % span;
        case (md)
            1:       return (p % (2 * mfv)) < mfv;
            2:       return p < 2 * mfv;
            3:       return !((p % mfv) < mfv / 2);
            default: return (p % mfv) < mfv / 2;
        endcase
    endfunction

    function automatic bit stop_of(input int b, input int c, input bit plv);
        return (b == 3 && c == 8 && !plv);
    endfunction

    task automatic chk(input string tag, input int b, input int got, input int exp);
        nvec++;
        if (got !== exp) begin
            nbad++;
            $display("FAIL %s bank %0d t=%0d: got %0d expected %0d", tag, b + 1, t, got, exp);
        end
    endtask

    task automatic set_codes(input int c0, input int c1, input int c2, input int c3);
        bank_sel = {pins_of(c3), pins_of(c2), pins_of(c1), pins_of(c0)};
    endtask

    task automatic runt_arm();
        for (int b = 0; b < 4; b++) begin
            run_len[b]  = 1000;
            last_lvl[b] = clk_o[2*b];
        end
        runt_on = 1'b1;
    endtask

    task automatic start(input logic [1:0] rr, input int mfn, input logic [1:0] er,
                         input int c0, input int c1, input int c2, input int c3);
        @(negedge clk);
        rst = 1'b1;
        range_sel = rr;
        edge_sel = er;
        test_sel = 2'd0;
        hold = 1'b0;
        set_codes(c0, c1, c2, c3);
        code_now = '{c0, c1, c2, c3};
        code_nxt = code_now;
        t_sw = NEVER;
        stopped = '{1'b0, 1'b0, 1'b0, 1'b0};
        runt_on = 1'b0;
        pl = (er == 2'd0);
        repeat (2) @(negedge clk);
        chk("R12 reset level", 0, int'(clk_o), 0);
        rst = 1'b0;
        // R12: first base period after reset runs range M, all codes MM
        for (int k = 0; k < 16; k++) begin
            @(posedge clk);
            @(negedge clk);
            for (int b = 0; b < 4; b++) begin
                bit e = model(b, 4, 16, pl, k);
                chk("R12 post-reset MM", b, int'(clk_o[2*b +: 2]), int'({e, e}));
            end
        end
        repeat (48) @(posedge clk);
        mf = mfn;
        t = 0;
    endtask

    task automatic run(input int n, input bit cmp, input string tag);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
            for (int b = 0; b < 4; b++) begin
                int c = (t >= t_sw) ? code_nxt[b] : code_now[b];
                bit e = stopped[b] ? stop_of(b, c, pl) : model(b, c, mf, pl, t % (4 * mf));
                bit [1:0] got = clk_o[2*b +: 2];
                if (cmp) chk(tag, b, int'(got), int'({e, e}));
                if (runt_on) begin
                    if (got[0] != last_lvl[b]) begin
                        chk("R10 run length", b, int'(run_len[b] >= mf / 2), 1);
                        run_len[b]  = 1;
                        last_lvl[b] = got[0];
                    end else begin
                        run_len[b]++;
                    end
                end
            end
            t++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 120000);
        nbad++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        int mf_of[4] = '{32, 16, 8, 16};

        // R1 R2 R3 R4 R5 R6: every range encoding, polarity and code
        for (int ri = 0; ri < 4; ri++)
            for (int pi = 0; pi < 3; pi++)
                for (int c = 0; c < 9; c++) begin
                    start(2'(ri), mf_of[ri], 2'(pi), c, c, c, c);
                    run(8 * mf_of[ri], 1'b1, "R1/R2/R3/R4/R5/R6");
                end

        // R11: code change mid-period lands at the next multiple of MF
        start(2'd2, 8, 2'd2, 4, 4, 4, 4);
        run(35, 1'b1, "R11");
        code_nxt = '{8, 4, 4, 3};
        set_codes(8, 4, 4, 3);
        t_sw = (t / mf + 1) * mf;
        run(96, 1'b1, "R11 code switch");
        code_now = code_nxt;
        t_sw = NEVER;
        // R11: range change lands at the wrap
        range_sel = 2'd0;
        run(4 * mf - (t % (4 * mf)), 1'b1, "R11 range hold");
        mf = 32;
        t = 0;
        run(256, 1'b1, "R11 range switch");

        // R7 R10: hold stops banks 1, 3, 4 low, bank 2 runs
        start(2'd1, 16, 2'd2, 4, 4, 4, 4);
        run(64, 1'b1, "R7");
        hold = 1'b1;
        runt_arm();
        run(64, 1'b0, "R10");
        stopped = '{1'b1, 1'b0, 1'b1, 1'b1};
        run(128, 1'b1, "R7 held");
        hold = 1'b0;
        run(64, 1'b0, "R10");
        stopped = '{1'b0, 1'b0, 1'b0, 1'b0};
        run(128, 1'b1, "R7 released");
        runt_on = 1'b0;

        // R8: inverted bank 4 rest level follows polarity
        for (int pi = 0; pi < 3; pi++) begin
            start(2'd2, 8, 2'(pi), 4, 4, 4, 8);
            run(32, 1'b1, "R5");
            hold = 1'b1;
            runt_arm();
            run(32, 1'b0, "R10");
            stopped = '{1'b1, 1'b0, 1'b1, 1'b1};
            run(64, 1'b1, "R8");
            runt_on = 1'b0;
        end

        // R9: test mid, only LL banks stop under hold
        start(2'd1, 16, 2'd2, 0, 4, 0, 4);
        run(64, 1'b1, "R9 normal");
        test_sel = 2'd1;
        run(64, 1'b1, "R9 test mid no hold");
        hold = 1'b1;
        runt_arm();
        run(64, 1'b0, "R10");
        stopped = '{1'b1, 1'b0, 1'b1, 1'b0};
        run(128, 1'b1, "R9 test mid hold");
        runt_on = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule